// File: doc/BRIEF.md
# Once-per-second clock update sequencer

This block produces the update cycle of a real-time clock. A phase counter advances on each tick of a 32.768 kHz time base, which arrives as a one-cycle enable on the system clock. Each time the counter completes a second, the block moves the seconds, minutes and hours fields forward by one second. Before each move it raises an update-in-progress status bit as a warning to the host. After the move it compares the time against three alarm fields and pulses an update-ended flag. When the alarm fields match, it also pulses an alarm flag.

A host port writes the time and alarm fields. The host's control fields enter as plain inputs: a three-bit divider code, a set-mode bit, a binary/BCD select and a 12/24-hour select. The divider runs only on its normal code. Two codes hold the divider in reset, and every other code freezes its phase. Set mode keeps the divider running but blocks updates, so the host can load a new time. Day, date and daylight-saving handling belong to other logic.

Top module: `rtc_sec_update`

## Requirements
- R1: While `rst_n` is low at a clock edge, `uip`, `upd_flag` and `alm_flag` go to 0 and `sec_o`, `min_o` and `hour_o` go to 0x00.
- R2: `dv_sel` = 3'b010 runs the divider. When the divider starts from phase zero, through reset or a reset code, the first time change follows exactly `DIV_TICKS` ticks later.
- R3: `uip` rises exactly `UIP_LEAD` ticks before the time fields change. The time fields never change by an update while `uip` is low.
- R4: `uip` stays high for `UPD_TICKS` ticks after the change and then falls. In the same cycle that it falls, `upd_flag` pulses high for one clock cycle.
- R5: In BCD mode (`bin_mode` = 0), seconds and minutes roll from 0x59 to 0x00 and carry into the next field. A digit of 9 carries into the tens digit, so 0x09 becomes 0x10.
- R6: In binary mode (`bin_mode` = 1), fields count as plain binary. 59 rolls to 0 with a carry, and 9 becomes 10 (0x0A).
- R7: In 24-hour mode (`h24_mode` = 1), hours roll from 23 to 0 when the minutes carry.
- R8: In 12-hour mode, hour bit 7 is the PM flag and bits 6..0 hold 1 to 12. The count goes 12, 1, …, 11. Moving from 11 to 12 toggles PM: 0x11 becomes 0x92, 0x92 becomes 0x81 and 0x12 becomes 0x01 in BCD. In binary, 11 becomes 0x8C.
- R9: `alm_flag` pulses together with `upd_flag` only when seconds, minutes and hours all equal their alarm fields after the update.
- R10: While `set_mode` is 1, `uip` does not rise and no update occurs, but the divider keeps counting. After `set_mode` clears, the next update lands on the next second boundary of the running phase.
- R11: `dv_sel` = 3'b110 or 3'b111 holds the phase at zero, and no updates occur.
- R12: Any other `dv_sel` code freezes the phase. When the code returns to 3'b010, counting resumes from the frozen phase.
- R13: A host write at `wr_addr` 0, 2 or 4 loads seconds, minutes or hours. A write at 1, 3 or 5 loads the alarm seconds, minutes or hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz tick |
| dv_sel | input | 3 | Divider control code |
| set_mode | input | 1 | Blocks updates while high |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| uip | output | 1 | Update-in-progress status |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| upd_flag | output | 1 | One-cycle update-ended pulse |
| alm_flag | output | 1 | One-cycle alarm-match pulse |

## Verification
Four properties are checked on every cycle. Time fields change only behind a raised `uip`. An update always moves the seconds field. `uip` can only rise while set mode is clear. The update and alarm flags keep their ordering with `uip`. The directed scenarios must show the rest, because those checks depend on counted ticks and on field values. They cover the exact tick distances of the warning window and the hold window, and the BCD, binary and 12-hour roll sequences. They also cover the phase kept across set mode and the phase kept across a frozen divider, and the alarm comparison.

// File: rtl/rtc_upd_pkg.sv
// Package: shared addresses, sequencer state type and field-step functions.
// Assumes fields are 8 bits wide, in BCD or plain binary.
package rtc_upd_pkg;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_MIN   = 4'd2;
    localparam logic [3:0] A_HOUR  = 4'd4;
    localparam logic [2:0] DV_RUN  = 3'b010;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_HOLD} upd_state_t;

    // Add one, carrying a BCD low digit of 9 into the tens digit.
    function automatic logic [7:0] bump(input logic [7:0] v, input logic bin);
        if (bin || v[3:0] < 4'd9)
            return v + 8'd1;
        return {v[7:4] + 4'd1, 4'd0};
    endfunction

    // Seconds/minutes step: returns {carry, next}.
    function automatic logic [8:0] step59(input logic [7:0] v, input logic bin);
        logic top;
        top = bin ? (v >= 8'd59) : (v >= 8'h59);
        if (top)
            return {1'b1, 8'h00};
        return {1'b0, bump(v, bin)};
    endfunction

    // Hours step for 24-hour or 12-hour (bit 7 = PM) form.
    function automatic logic [7:0] next_hour(input logic [7:0] v, input logic bin,
                                             input logic h24);
        logic [7:0] h;
        logic [7:0] twelve;
        logic [7:0] eleven;
        logic [7:0] nx;
        if (h24) begin
            if (bin ? (v >= 8'd23) : (v >= 8'h23))
                return 8'h00;
            return bump(v, bin);
        end
        h      = {1'b0, v[6:0]};
        twelve = bin ? 8'd12 : 8'h12;
        eleven = bin ? 8'd11 : 8'h11;
        nx     = bump(h, bin);
        if (h >= twelve)
            return {v[7], 7'd1};
        if (h == eleven)
            return {~v[7], twelve[6:0]};
        return {v[7], nx[6:0]};
    endfunction

endpackage

// File: rtl/rtc_div_chain.sv
// Divider phase counter: counts ticks through one second and marks the
// warning point and the second boundary. Assumes DIV_TICKS > UIP_LEAD + 1.
module rtc_div_chain
    import rtc_upd_pkg::*;
#(
    parameter int DIV_TICKS = 32768,
    parameter int UIP_LEAD  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] dv_sel,
    output logic       div_run,
    output logic       lead_hit,
    output logic       sec_hit
);
    localparam int PH_W = $clog2(DIV_TICKS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_TICKS - 1);
    localparam logic [PH_W-1:0] PH_LEAD = PH_W'(DIV_TICKS - 1 - UIP_LEAD);

    logic [PH_W-1:0] ph_q;
    logic            dv_rst;

    // Decode the divider code into run and reset conditions.
    always_comb begin
        div_run  = (dv_sel == DV_RUN);
        dv_rst   = (dv_sel[2:1] == 2'b11);
        lead_hit = div_run && tick_en && (ph_q == PH_LEAD);
        sec_hit  = div_run && tick_en && (ph_q == PH_LAST);
    end

    // Advance the phase on each tick, hold at zero in reset, else freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || dv_rst)
            ph_q <= '0;
        else if (div_run && tick_en)
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end

endmodule

// File: rtl/rtc_upd_ctrl.sv
// Update sequencer: raises the in-progress bit at the warning point, fires
// the time advance at the boundary, holds for UPD_TICKS ticks, then pulses
// the flags. Assumes UPD_TICKS >= 1.
module rtc_upd_ctrl
    import rtc_upd_pkg::*;
#(
    parameter int UPD_TICKS = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_run,
    input  logic lead_hit,
    input  logic sec_hit,
    input  logic set_mode,
    input  logic alarm_hit,
    output logic uip,
    output logic adv,
    output logic upd_flag,
    output logic alm_flag
);
    localparam int CW = $clog2(UPD_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(UPD_TICKS - 1);

    upd_state_t      st_q;
    logic [CW-1:0]   cnt_q;

    // Status and advance strobe from the state.
    always_comb begin
        uip = (st_q != ST_IDLE);
        adv = (st_q == ST_LEAD) && sec_hit && !set_mode;
    end

    // Sequence warning, advance and hold windows; emit one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            upd_flag <= 1'b0;
            alm_flag <= 1'b0;
        end else begin
            upd_flag <= 1'b0;
            alm_flag <= 1'b0;
            case (st_q)
                ST_IDLE: if (lead_hit && !set_mode) st_q <= ST_LEAD;
                ST_LEAD: begin
                    if (set_mode || !div_run) begin
                        st_q <= ST_IDLE;
                    end else if (sec_hit) begin
                        st_q  <= ST_HOLD;
                        cnt_q <= '0;
                    end
                end
                ST_HOLD: begin
                    if (tick_en) begin
                        if (cnt_q == CNT_LAST) begin
                            st_q     <= ST_IDLE;
                            upd_flag <= 1'b1;
                            alm_flag <= alarm_hit;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    uip_rise_needs_clear_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(!set_mode));

endmodule

// File: rtl/rtc_time_regs.sv
// Time and alarm fields: host writes, one-second advance with carries, and
// the alarm compare. A host write wins over an advance on the same field.
module rtc_time_regs
    import rtc_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       alarm_hit
);
    localparam int N_ALM = 3;

    logic [7:0] sec_q, min_q, hour_q;
    logic [8:0] sec_nx, min_nx;
    logic [7:0] hour_nx;
    logic       wr_sec, wr_min, wr_hour;
    logic [N_ALM-1:0] alm_eq;
    logic [7:0] cur [N_ALM];

    // Next values and write decodes.
    always_comb begin
        sec_nx  = step59(sec_q, bin_mode);
        min_nx  = step59(min_q, bin_mode);
        hour_nx = next_hour(hour_q, bin_mode, h24_mode);
        wr_sec  = wr_en && (wr_addr == A_SEC);
        wr_min  = wr_en && (wr_addr == A_MIN);
        wr_hour = wr_en && (wr_addr == A_HOUR);
        cur[0]  = sec_q;
        cur[1]  = min_q;
        cur[2]  = hour_q;
    end

    // Seconds field.
    always_ff @(posedge clk) begin
        if (!rst_n)      sec_q <= 8'h00;
        else if (wr_sec) sec_q <= wr_data;
        else if (adv)    sec_q <= sec_nx[7:0];
    end

    // Minutes field, advanced on a seconds carry.
    always_ff @(posedge clk) begin
        if (!rst_n)                    min_q <= 8'h00;
        else if (wr_min)               min_q <= wr_data;
        else if (adv && sec_nx[8])     min_q <= min_nx[7:0];
    end

    // Hours field, advanced on a minutes carry.
    always_ff @(posedge clk) begin
        if (!rst_n)                              hour_q <= 8'h00;
        else if (wr_hour)                        hour_q <= wr_data;
        else if (adv && sec_nx[8] && min_nx[8])  hour_q <= hour_nx;
    end

    // Alarm fields at odd addresses 1, 3, 5, each paired with a time field.
    for (genvar i = 0; i < N_ALM; i++) begin : g_alm
        logic [7:0] val_q;
        // Load one alarm field from the host port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= 8'h00;
            else if (wr_en && (wr_addr == 4'(2 * i + 1)))
                val_q <= wr_data;
        end
        assign alm_eq[i] = (cur[i] == val_q);
    end

    assign alarm_hit = &alm_eq;
    assign sec_o     = sec_q;
    assign min_o     = min_q;
    assign hour_o    = hour_q;

    // R5
    adv_moves_seconds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !wr_sec |=> sec_q != $past(sec_q));

endmodule

// File: rtl/rtc_sec_update.sv
// Top: joins the divider, the update sequencer and the time fields.
// Assumes tick_en is a one-cycle pulse per reference tick.
module rtc_sec_update #(
    parameter int DIV_TICKS = 32768,
    parameter int UIP_LEAD  = 8,
    parameter int UPD_TICKS = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] dv_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       uip,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       upd_flag,
    output logic       alm_flag
);
    logic div_run, lead_hit, sec_hit, adv, alarm_hit;

    rtc_div_chain #(.DIV_TICKS(DIV_TICKS), .UIP_LEAD(UIP_LEAD)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dv_sel(dv_sel),
        .div_run(div_run), .lead_hit(lead_hit), .sec_hit(sec_hit)
    );

    rtc_upd_ctrl #(.UPD_TICKS(UPD_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_run(div_run),
        .lead_hit(lead_hit), .sec_hit(sec_hit), .set_mode(set_mode),
        .alarm_hit(alarm_hit), .uip(uip), .adv(adv),
        .upd_flag(upd_flag), .alm_flag(alm_flag)
    );

    rtc_time_regs u_regs (
        .clk(clk), .rst_n(rst_n), .adv(adv), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .alarm_hit(alarm_hit)
    );

    // R3
    change_behind_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o != $past(sec_o)) && !$past(wr_en) |-> $past(uip));

    // R4
    flag_after_uip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_flag |-> !uip && $past(uip));

    // R9
    alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_flag |-> upd_flag);

endmodule

// File: tb/sim_rtc_sec_update.sv
module sim_rtc_sec_update;
    localparam int DIVT = 64;
    localparam int LEAD = 8;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [2:0] dv_sel = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       uip, upd_flag, alm_flag;
    logic [7:0] sec_o, min_o, hour_o;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_sec_update #(.DIV_TICKS(DIVT), .UIP_LEAD(LEAD), .UPD_TICKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dv_sel(dv_sel),
        .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .uip(uip),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .upd_flag(upd_flag), .alm_flag(alm_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic sync_div();
        @(negedge clk); dv_sel = 3'b110;
        @(negedge clk); dv_sel = 3'b010;
    endtask

    task automatic wait_update(output int af);
        int got = 0;
        af = -1;
        for (int i = 0; i < 4 * DIVT && got == 0; i++) begin
            @(negedge clk);
            if (upd_flag) begin got = 1; af = int'(alm_flag); end
        end
        chk("R4 update flag seen", got, 1);
    endtask

    task automatic t_reset_timing();
        int rise_n = 0, chg_n = 0, fall_n = 0, uf_n = 0, uf_cnt = 0;
        repeat (3) @(negedge clk);
        chk("R1 uip", int'(uip), 0);
        chk("R1 sec", int'(sec_o), 0);
        chk("R1 hour", int'(hour_o), 0);
        chk("R1 flags", int'({upd_flag, alm_flag}), 0);
        rst_n = 1'b1;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (uip && rise_n == 0) rise_n = n;
            if (sec_o != 8'h00 && chg_n == 0) chg_n = n;
            if (!uip && rise_n != 0 && fall_n == 0) fall_n = n;
            if (upd_flag) begin uf_cnt++; if (uf_n == 0) uf_n = n; end
        end
        chk("R2 first change tick", chg_n, DIVT);
        chk("R3 uip lead tick", rise_n, DIVT - LEAD);
        chk("R4 uip fall tick", fall_n, DIVT + HOLD);
        chk("R4 flag tick", uf_n, DIVT + HOLD);
        chk("R4 flag width", uf_cnt, 1);
        chk("R2 sec after first", int'(sec_o), 8'h01);
    endtask

    task automatic t_bcd();
        int af;
        bin_mode = 1'b0; h24_mode = 1'b1;
        wr(4'd0, 8'h59); wr(4'd2, 8'h59); wr(4'd4, 8'h23);
        wait_update(af);
        chk("R5 bcd sec roll", int'(sec_o), 8'h00);
        chk("R5 bcd min roll", int'(min_o), 8'h00);
        chk("R7 bcd hour roll", int'(hour_o), 8'h00);
        wr(4'd0, 8'h09); wr(4'd2, 8'h14);
        wait_update(af);
        chk("R5 bcd digit carry", int'(sec_o), 8'h10);
        chk("R5 min unchanged", int'(min_o), 8'h14);
    endtask

    task automatic t_binary();
        int af;
        bin_mode = 1'b1; h24_mode = 1'b1;
        wr(4'd0, 8'd59); wr(4'd2, 8'd59); wr(4'd4, 8'd23);
        wait_update(af);
        chk("R6 bin sec roll", int'(sec_o), 0);
        chk("R6 bin min roll", int'(min_o), 0);
        chk("R7 bin hour roll", int'(hour_o), 0);
        wr(4'd0, 8'd9); wr(4'd2, 8'd5);
        wait_update(af);
        chk("R6 bin sec 9 to 10", int'(sec_o), 8'h0A);
        chk("R6 bin min held", int'(min_o), 8'd5);
    endtask

    task automatic t_12h();
        int af;
        bin_mode = 1'b0; h24_mode = 1'b0;
        wr(4'd4, 8'h11); wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        wait_update(af);
        chk("R8 11am to 12pm", int'(hour_o), 8'h92);
        wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        wait_update(af);
        chk("R8 12pm to 1pm", int'(hour_o), 8'h81);
        wr(4'd4, 8'h12); wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        wait_update(af);
        chk("R8 12am to 1am", int'(hour_o), 8'h01);
        bin_mode = 1'b1;
        wr(4'd4, 8'd11); wr(4'd2, 8'd59); wr(4'd0, 8'd59);
        wait_update(af);
        chk("R8 bin 11am to 12pm", int'(hour_o), 8'h8C);
    endtask

    task automatic t_alarm();
        int af;
        bin_mode = 1'b0; h24_mode = 1'b1;
        wr(4'd0, 8'h10); wr(4'd2, 8'h20); wr(4'd4, 8'h05);
        wr(4'd1, 8'h11); wr(4'd3, 8'h20); wr(4'd5, 8'h05);
        wait_update(af);
        chk("R9 alarm match", af, 1);
        chk("R13 sec written then advanced", int'(sec_o), 8'h11);
        chk("R13 hour written", int'(hour_o), 8'h05);
        wait_update(af);
        chk("R9 no alarm on mismatch", af, 0);
    endtask

    task automatic t_set();
        int uips = 0, chgs = 0, chg_n = 0;
        logic [7:0] s0;
        sync_div();
        set_mode = 1'b1;
        s0 = sec_o;
        for (int n = 1; n <= 140; n++) begin
            @(negedge clk);
            if (n <= 100) begin
                if (uip) uips++;
                if (sec_o != s0) chgs++;
            end else if (sec_o != s0 && chg_n == 0) begin
                chg_n = n;
            end
            if (n == 100) set_mode = 1'b0;
        end
        chk("R10 no uip in set", uips, 0);
        chk("R10 no change in set", chgs, 0);
        chk("R10 phase kept across set", chg_n, 2 * DIVT);
    endtask

    task automatic t_divrst();
        int uips = 0, chgs = 0, chg_n = 0;
        logic [7:0] s0;
        @(negedge clk); dv_sel = 3'b111;
        s0 = sec_o;
        for (int n = 1; n <= 150; n++) begin
            @(negedge clk);
            if (uip) uips++;
            if (sec_o != s0) chgs++;
            if (n == 75) dv_sel = 3'b110;
        end
        chk("R11 no uip in reset", uips, 0);
        chk("R11 no change in reset", chgs, 0);
        dv_sel = 3'b010;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (sec_o != s0 && chg_n == 0) chg_n = n;
        end
        chk("R11 one second after release", chg_n, DIVT);
    endtask

    task automatic t_freeze();
        int chgs = 0, chg_n = 0;
        logic [7:0] s0;
        sync_div();
        repeat (30) @(negedge clk);
        dv_sel = 3'b000;
        s0 = sec_o;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (sec_o != s0 || uip) chgs++;
        end
        chk("R12 frozen no activity", chgs, 0);
        dv_sel = 3'b010;
        for (int n = 1; n <= 50; n++) begin
            @(negedge clk);
            if (sec_o != s0 && chg_n == 0) chg_n = n;
        end
        chk("R12 resume from frozen phase", chg_n, DIVT - 30);
    endtask

    initial begin
        t_reset_timing();
        t_bcd();
        t_binary();
        t_12h();
        t_alarm();
        t_set();
        t_divrst();
        t_freeze();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule